// File: doc/BRIEF.md
# Key-Expansion Assist Unit

This block computes the helper value that an AES-128 key schedule step uses to derive its next round key. A 128-bit word group and an 8-bit round constant are presented together with a one-cycle valid strobe. The unit passes two of the four 32-bit input words through the cipher's byte substitution. It writes each substituted word into the result twice. The first copy is unchanged. The second copy is rotated by one byte position, and the round constant is folded into its lowest byte.

The result is registered. It appears one clock after the strobe together with a single-cycle valid pulse. It then stays on the output until the next strobe, so a consumer can sample it at leisure. The substitution table is not stored. Each byte lane computes it from the field inverse modulo x^8+x^4+x^3+x+1, followed by the affine map with constant 0x63.

Top module: `keyexp_assist`

## Requirements
- R1: Output bits [31:0] equal the byte substitution of input word 1 (input bits [63:32]), applied to each byte in place.
- R2: Output bits [63:32] equal the substituted input word 1, rotated, with the round constant XORed in.
- R3: Output bits [95:64] equal the byte substitution of input word 3 (input bits [127:96]).
- R4: Output bits [127:96] equal the substituted input word 3, rotated, with the round constant XORed in.
- R5: The rotation places the substituted bytes 1, 2, 3, 0 of the source word at byte positions 0, 1, 2, 3 of the rotated word. Byte 0 is bits [7:0].
- R6: The round constant is zero-extended to 32 bits. It changes only output bits [39:32] and [103:96], and never any other output bit.
- R7: Input word 0 (bits [31:0]) and input word 2 (bits [95:64]) have no effect on the output.
- R8: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and is low otherwise.
- R9: `out_data` keeps its value in every cycle that does not follow an `in_valid` cycle.
- R10: While `rst_n` is low, `out_valid` is 0 and `out_data` is all zeros, even if `in_valid` is high.
- R11: The byte substitution is the multiplicative inverse in GF(2^8) modulo 0x11B (with 0 mapping to 0), followed by the affine map with constant 0x63. As examples, 0x00 maps to 0x63 and 0x09 maps to 0x01. No byte maps to itself or to its complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: capture the result for the present inputs |
| in_data | input | 128 | Four 32-bit source words, word 0 in the low bits |
| in_rcon | input | 8 | Round constant |
| out_valid | output | 1 | One-cycle pulse marking a fresh result |
| out_data | output | 128 | Registered helper value |

## Verification
An input whose sixteen bytes are all distinct exposes the direction of the rotation. A mistaken rotation would put a different substituted byte at every position of words 1 and 3. All-zero inputs and a known key word give fixed substitution results, which separate a correct table from a merely consistent one. The round constants 0x01, 0x02, 0x80, 0x1B and 0x36 exercise the constant lane, and comparing each result with the zero-constant result shows that the constant reaches only one byte per word. Pairs of inputs that differ only in words 0 and 2 show that those words are ignored, and random inputs are compared over all 128 bits against an independent model.

// File: rtl/keyexp_pkg.sv
package keyexp_pkg;

  localparam int BYTE_W = 8;
  localparam logic [7:0] AFFINE_CONST = 8'h63;
  localparam logic [7:0] FIELD_REDUCE = 8'h1B;   // low byte of x^8+x^4+x^3+x+1

  typedef logic [BYTE_W-1:0] kbyte_t;

  // Multiply by x in GF(2^8).
  function automatic kbyte_t gf_xtime(input kbyte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? FIELD_REDUCE : 8'h00);
  endfunction

  // Shift-and-add multiplication in GF(2^8).
  function automatic kbyte_t gf_mul(input kbyte_t a, input kbyte_t b);
    kbyte_t acc;
    kbyte_t p;
    acc = '0;
    p   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_xtime(p);
    end
    return acc;
  endfunction

  // Inverse as a^254: the product of a^(2^i) for i = 1..7. Zero maps to zero.
  function automatic kbyte_t gf_inv(input kbyte_t a);
    kbyte_t acc;
    kbyte_t sq;
    acc = 8'h01;
    sq  = a;
    for (int i = 1; i < BYTE_W; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic kbyte_t rotl8(input kbyte_t v, input int n);
    logic [2*BYTE_W-1:0] dbl;
    dbl = {v, v} << n;
    return dbl[2*BYTE_W-1:BYTE_W];
  endfunction

  function automatic kbyte_t affine_map(input kbyte_t v);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ AFFINE_CONST;
  endfunction

  function automatic kbyte_t sub_byte(input kbyte_t v);
    return affine_map(gf_inv(v));
  endfunction

endpackage

// File: rtl/kx_sbox.sv
module kx_sbox
  import keyexp_pkg::*;
(
  input  kbyte_t byte_i,
  output kbyte_t sub_o
);

  assign sub_o = sub_byte(byte_i);

  // R11: the substitution has no fixed points and no opposite fixed points
  always_comb begin
    assert_no_fixed_point_R11: assert ((sub_o != byte_i) && (sub_o != ~byte_i));
  end

endmodule

// File: rtl/kx_subword.sv
module kx_subword
  import keyexp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);

  localparam int N_BYTES = WORD_W / BYTE_W;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
    kx_sbox u_sbox (
      .byte_i (word_i[b*BYTE_W +: BYTE_W]),
      .sub_o  (word_o[b*BYTE_W +: BYTE_W])
    );
  end

endmodule

// File: rtl/kx_word_pack.sv
module kx_word_pack
  import keyexp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RC_W   = 8
) (
  input  logic [WORD_W-1:0] sub_i,
  input  logic [RC_W-1:0]   rcon_i,
  output logic [WORD_W-1:0] plain_o,
  output logic [WORD_W-1:0] mixed_o
);

  localparam int PAD_W = WORD_W - RC_W;

  logic [WORD_W-1:0] rot_w;
  logic [WORD_W-1:0] rcon_ext;

  // lowest byte moves to the top, so byte k of rot_w is byte k+1 of sub_i
  assign rot_w    = {sub_i[BYTE_W-1:0], sub_i[WORD_W-1:BYTE_W]};
  assign rcon_ext = {{PAD_W{1'b0}}, rcon_i};
  assign plain_o  = sub_i;
  assign mixed_o  = rot_w ^ rcon_ext;

endmodule

// File: rtl/keyexp_assist.sv
module keyexp_assist
  import keyexp_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int RC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [RC_W-1:0]   in_rcon,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int N_WORDS = 4;
  localparam int WORD_W  = DATA_W / N_WORDS;
  localparam int N_SRC   = N_WORDS / 2;   // odd-indexed words are the sources

  logic [DATA_W-1:0] next_res;
  logic              capture_evt;

  assign capture_evt = in_valid;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    localparam int SRC_IDX = 2*g + 1;
    logic [WORD_W-1:0] src_w;
    logic [WORD_W-1:0] sub_w;
    logic [WORD_W-1:0] plain_w;
    logic [WORD_W-1:0] mixed_w;

    assign src_w = in_data[SRC_IDX*WORD_W +: WORD_W];

    kx_subword #(.WORD_W(WORD_W)) u_subword (
      .word_i (src_w),
      .word_o (sub_w)
    );

    kx_word_pack #(.WORD_W(WORD_W), .RC_W(RC_W)) u_pack (
      .sub_i   (sub_w),
      .rcon_i  (in_rcon),
      .plain_o (plain_w),
      .mixed_o (mixed_w)
    );

    assign next_res[(2*g)*WORD_W   +: WORD_W] = plain_w;
    assign next_res[(2*g+1)*WORD_W +: WORD_W] = mixed_w;

    // R2, R4, R5, R6: rotated copy matches the plain copy outside the constant byte
    assert_rot_rcon_R2_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |->
        (out_data[(2*g+1)*WORD_W+BYTE_W +: WORD_W-BYTE_W] ==
         {out_data[(2*g)*WORD_W +: BYTE_W],
          out_data[(2*g)*WORD_W+2*BYTE_W +: WORD_W-2*BYTE_W]}) &&
        ((out_data[(2*g+1)*WORD_W +: BYTE_W] ^
          out_data[(2*g)*WORD_W+BYTE_W +: BYTE_W]) ==
         {{(BYTE_W-RC_W){1'b0}}, $past(in_rcon)}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= capture_evt;
      if (capture_evt) out_data <= next_res;
    end
  end

  // R8: one result pulse per strobe, one cycle later
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9: result holds between strobes
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R10: reset keeps the output idle and cleared
  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && (out_data == '0)));

endmodule

// File: tb/keyexp_assist_tb.sv
module keyexp_assist_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_data;
  logic [7:0]   in_rcon;
  logic         out_valid;
  logic [127:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  keyexp_assist u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_rcon   (in_rcon),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // ---------------- independent reference model ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] prod;
    prod = '0;
    for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h011B << (i - 8));
    return prod[7:0];
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] r;
    logic [7:0] c;
    inv = 8'h00;
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    c = 8'h63;
    for (int i = 0; i < 8; i++)
      r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return r;
  endfunction

  function automatic logic [127:0] m_ref(input logic [127:0] d, input logic [7:0] rc);
    logic [7:0] o [16];
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      o[k]    = m_sbox(d[(4+k)*8 +: 8]);
      o[4+k]  = m_sbox(d[(4+(k+1)%4)*8 +: 8]);
      o[8+k]  = m_sbox(d[(12+k)*8 +: 8]);
      o[12+k] = m_sbox(d[(12+(k+1)%4)*8 +: 8]);
    end
    o[4]  = o[4] ^ rc;
    o[12] = o[12] ^ rc;
    for (int k = 0; k < 16; k++) r[k*8 +: 8] = o[k];
    return r;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] d, input logic [7:0] rc);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_rcon  = rc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // stimulus table: {rcon, data}
  localparam int N_VEC = 8;
  localparam logic [135:0] VEC [N_VEC] = '{
    {8'h01, 128'h0f0e0d0c_0b0a0908_07060504_03020100},
    {8'h02, 128'h0f0e0d0c_0b0a0908_07060504_03020100},
    {8'h80, 128'h3c4fcf09_8815f7ab_a6d2ae28_16157e2b},
    {8'h1b, 128'hffffffff_00000000_ffffffff_00000000},
    {8'h36, 128'h01234567_89abcdef_fedcba98_76543210},
    {8'h00, 128'h00000000_00000000_00000000_00000000},
    {8'hff, 128'h80402010_08040201_c0a09050_28140a05},
    {8'h36, 128'hdeadbeef_cafef00d_0badf00d_feedface}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] base;
    logic [127:0] other;
    logic [127:0] d;
    logic [7:0]   rcl [5];

    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_data  = 128'h0123_4567_89ab_cdef_0123_4567_89ab_cdef;
    in_rcon  = 8'h5a;
    repeat (3) @(negedge clk);
    // R10: reset wins over a strobe
    chk(out_valid == 1'b0, "R10 valid in reset", 128'(out_valid), 128'h0);
    chk(out_data == '0, "R10 data in reset", out_data, 128'h0);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid after release", 128'(out_valid), 128'h0);

    // table walk: R1 R2 R3 R4 full-width, R8 pulse timing
    for (int v = 0; v < N_VEC; v++) begin
      apply(VEC[v][127:0], VEC[v][135:128]);
      chk(out_valid == 1'b1, "R8 valid after strobe", 128'(out_valid), 128'h1);
      chk(out_data == m_ref(VEC[v][127:0], VEC[v][135:128]), "R1/R2/R3/R4 table",
          out_data, m_ref(VEC[v][127:0], VEC[v][135:128]));
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 single pulse", 128'(out_valid), 128'h0);
    end

    // R11 known answers: zero input gives 0x63 everywhere except the constant byte
    apply('0, 8'h01);
    chk(out_data == 128'h63636362_63636363_63636362_63636363, "R11 zero input",
        out_data, 128'h63636362_63636363_63636362_63636363);
    // R11/R3/R4: known key word 09 cf 4f 3c gives 01 8a 84 eb
    apply(128'h3c4fcf09_00000000_00000000_00000000, 8'h01);
    chk(out_data[127:64] == 64'h01eb848b_eb848a01, "R11 known word",
        {64'h0, out_data[127:64]}, {64'h0, 64'h01eb848b_eb848a01});

    // R5: distinct bytes reveal rotation direction
    d = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    apply(d, 8'h00);
    chk(out_data[39:32] == m_sbox(8'h05) && out_data[63:56] == m_sbox(8'h04),
        "R5 rotation word1", {96'h0, out_data[63:32]},
        {96'h0, m_sbox(8'h04), m_sbox(8'h07), m_sbox(8'h06), m_sbox(8'h05)});
    chk(out_data[103:96] == m_sbox(8'h0d) && out_data[127:120] == m_sbox(8'h0c),
        "R5 rotation word3", {96'h0, out_data[127:96]},
        {96'h0, m_sbox(8'h0c), m_sbox(8'h0f), m_sbox(8'h0e), m_sbox(8'h0d)});
    base = out_data;

    // R6: each listed constant alters only bytes 4 and 12
    rcl = '{8'h01, 8'h02, 8'h80, 8'h1b, 8'h36};
    for (int i = 0; i < 5; i++) begin
      apply(d, rcl[i]);
      other = {24'h0, rcl[i], 24'h0, 8'h00, 24'h0, rcl[i], 32'h0};
      chk((out_data ^ base) == other, "R6 constant lane", out_data ^ base, other);
    end

    // R7: words 0 and 2 ignored
    for (int i = 0; i < 4; i++) begin
      d = {$urandom, $urandom, $urandom, $urandom};
      apply(d, 8'h36);
      base = out_data;
      apply({d[127:96], 32'($urandom), d[63:32], 32'($urandom)}, 8'h36);
      chk(out_data == base, "R7 words 0 and 2 ignored", out_data, base);
    end

    // R9: hold while strobe is low and inputs move
    base = out_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_data = {$urandom, $urandom, $urandom, $urandom};
      in_rcon = 8'($urandom);
    end
    @(negedge clk);
    chk(out_data == base, "R9 hold without strobe", out_data, base);
    chk(out_valid == 1'b0, "R8 no strobe no pulse", 128'(out_valid), 128'h0);

    // back-to-back strobes: R8 stays high, each result fresh
    @(negedge clk);
    in_valid = 1'b1;
    d = 128'h11223344_55667788_99aabbcc_ddeeff00;
    in_data = d;
    in_rcon = 8'h02;
    @(negedge clk);
    chk(out_valid && out_data == m_ref(d, 8'h02), "R8 back-to-back first",
        out_data, m_ref(d, 8'h02));
    d = ~d;
    in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == m_ref(d, 8'h02), "R8 back-to-back second",
        out_data, m_ref(d, 8'h02));

    // random sweep: R1 R2 R3 R4 full-width
    for (int i = 0; i < 40; i++) begin
      logic [7:0] rc;
      d  = {$urandom, $urandom, $urandom, $urandom};
      rc = 8'($urandom);
      apply(d, rc);
      chk(out_data == m_ref(d, rc), "R1/R2/R3/R4 random", out_data, m_ref(d, rc));
    end

    // R10: reset in mid-run clears the result
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_data == '0 && !out_valid, "R10 mid-run reset", out_data, 128'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule